// File: doc/BRIEF.md
# DMA Channel Register Front End

This block is the software-facing register file of a four-channel DMA engine whose registers are all one byte wide. A host reaches it over a small byte bus (4-bit offset, write data, read data, write and read strobes). Each channel keeps a 16-bit memory address and a 16-bit transfer count. Both are loaded and read back as two byte accesses at one offset. A single shared byte pointer, toggled by every such access, chooses which half is touched. The count is held as the number of transfers minus one.

Besides the per-channel registers, the block holds a mask bit and a mode per channel, a terminal-count status byte that clears when read, and the commands that return the byte pointer to its low state, mask or unmask channels, and master-clear everything. A per-channel transfer tick input stands in for the data path. Each accepted tick advances the address, steps the count down and, at terminal count, either masks the channel or reloads it (autoinitialize). Software can therefore read back the residue exactly as it would after a real transfer.

Top module: `dmac_regif`

## Requirements
- R1: After reset every channel is masked (`chan_en` = 0), the status byte reads 0, and the byte pointer selects the low byte.
- R2: Channel n's address register sits at offset 2n and its count register at offset 2n+1. A 16-bit value is written or read as two accesses at that offset, low byte first, then high byte. Every read or write at offsets 0x0–0x7 toggles the byte pointer.
- R3: A write of any value to offset 0xC returns the byte pointer to the low-byte state.
- R4: A write to 0xA uses bits 1:0 as the channel and sets that channel's mask when bit 2 is 1, or clears it when bit 2 is 0. A write to 0xF loads all four masks from bits 3:0. A write to 0xE clears all four masks. `chan_en` is the inverse of the masks.
- R5: A tick on an unmasked, non-cascade channel increments its address, which wraps from 0xFFFF to 0x0000, and decrements its count. A tick on a masked channel changes nothing.
- R6: A count loaded as N−1 reaches terminal count on the Nth tick. The count then reads 0xFFFF, the channel's status bit is set and, without autoinitialize, the channel becomes masked.
- R7: With autoinitialize (mode bit 4 = 1), terminal count reloads the address and count with the values last written and leaves the channel unmasked.
- R8: A read at offset 0x8 returns the terminal-count bits in bits 3:0 and zeros in bits 7:4, then clears them. A terminal count in the same cycle as that read is kept.
- R9: A write to offset 0xD masks all channels, returns the byte pointer to low and clears the status.
- R10: A mode write at 0xB uses bits 1:0 as the channel. Bits 7:6 = 11 puts that channel in cascade, where ticks leave its address and count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte; side effects at the clock edge |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| xfer_tick | input | 4 | One transfer completed on each flagged channel |
| chan_en | output | 4 | Channel unmasked |

## Verification
The bench targets the byte pointer. It leaves the pointer half-way, then checks that both the clear command and master clear realign it. A design that ignored either would swap the halves of every later 16-bit value. Terminal count is driven from a count of zero and from an address of 0xFFFE. A wrong minus-one convention shows up as one tick too many or too few. A carry across the 64K wrap shows up as a wrong address. The bench also checks that a non-autoinitialize channel masks itself while an autoinitialize channel reloads and keeps running. A terminal count is made to land in the same cycle as a status read, which catches a design that lets the read-clear erase the new bit.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int NCH  = 4;
  localparam int CH_W = 2;

  localparam logic [3:0] OFS_STAT   = 4'h8;
  localparam logic [3:0] OFS_REQ    = 4'h9;
  localparam logic [3:0] OFS_SMASK  = 4'hA;
  localparam logic [3:0] OFS_MODE   = 4'hB;
  localparam logic [3:0] OFS_PTRCLR = 4'hC;
  localparam logic [3:0] OFS_MCLR   = 4'hD;
  localparam logic [3:0] OFS_UNMASK = 4'hE;
  localparam logic [3:0] OFS_AMASK  = 4'hF;

  localparam logic [1:0] MODE_CASCADE = 2'b11;
endpackage

// File: rtl/dmac_bptr.sv
module dmac_bptr (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic hi_sel
);
  logic hi_d;
  logic hi_en;

  always_comb begin
    hi_en = clr | step;
    hi_d  = clr ? 1'b0 : ~hi_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_sel <= 1'b0;
    else if (hi_en) hi_sel <= hi_d;
  end

  assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !hi_sel);
  assert_ptr_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> (hi_sel != $past(hi_sel)));
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan #(
  parameter int DATA_W = 8,
  localparam int REG_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hi_sel,
  input  logic              tick,
  input  logic              autoinit,
  output logic [REG_W-1:0]  cur_addr,
  output logic [REG_W-1:0]  cur_cnt,
  output logic              tc_hit
);
  logic [REG_W-1:0] base_addr, base_cnt;
  logic [REG_W-1:0] base_addr_d, base_cnt_d, cur_addr_d, cur_cnt_d;
  logic             upd_en;

  function automatic logic [REG_W-1:0] put_byte(input logic [REG_W-1:0] v,
                                                input logic h,
                                                input logic [DATA_W-1:0] b);
    logic [REG_W-1:0] r;
    r = v;
    if (h) r[REG_W-1:DATA_W] = b;
    else   r[DATA_W-1:0]     = b;
    return r;
  endfunction

  always_comb begin
    tc_hit      = tick && (cur_cnt == '0);
    upd_en      = tick | wr_addr | wr_cnt;
    base_addr_d = base_addr;
    base_cnt_d  = base_cnt;
    cur_addr_d  = cur_addr;
    cur_cnt_d   = cur_cnt;
    if (tick) begin
      if (tc_hit && autoinit) begin
        cur_addr_d = base_addr;
        cur_cnt_d  = base_cnt;
      end else begin
        cur_addr_d = cur_addr + 1'b1;
        cur_cnt_d  = cur_cnt - 1'b1;
      end
    end
    if (wr_addr) begin
      base_addr_d = put_byte(base_addr, hi_sel, wdata);
      cur_addr_d  = put_byte(cur_addr, hi_sel, wdata);
    end
    if (wr_cnt) begin
      base_cnt_d = put_byte(base_cnt, hi_sel, wdata);
      cur_cnt_d  = put_byte(cur_cnt, hi_sel, wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
    end else if (upd_en) begin
      base_addr <= base_addr_d;
      base_cnt  <= base_cnt_d;
      cur_addr  <= cur_addr_d;
      cur_cnt   <= cur_cnt_d;
    end
  end

  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && !(tc_hit && autoinit)) |=> (cur_cnt == $past(cur_cnt) - 1'b1));
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_addr && !(tc_hit && autoinit)) |=> (cur_addr == $past(cur_addr) + 1'b1));
  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_hit && autoinit && !wr_cnt && !wr_addr) |=>
      (cur_cnt == $past(base_cnt) && cur_addr == $past(base_addr)));
  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt && !wr_addr) |=> ($stable(cur_cnt) && $stable(cur_addr)));
endmodule

// File: rtl/dmac_flags.sv
module dmac_flags
  import dmac_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclr,
  input  logic              smask_wr,
  input  logic              amask_wr,
  input  logic              unmask_wr,
  input  logic              mode_wr,
  input  logic              stat_rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NCH-1:0]    tc_hit,
  output logic [NCH-1:0]    mask,
  output logic [NCH-1:0]    autoinit,
  output logic [NCH-1:0]    cascade,
  output logic [NCH-1:0]    status
);
  logic [NCH-1:0]  mask_d, auto_d, casc_d, status_d;
  logic [CH_W-1:0] wsel;
  logic            flag_en;

  always_comb begin
    wsel     = wdata[CH_W-1:0];
    flag_en  = mclr | smask_wr | amask_wr | unmask_wr | mode_wr | stat_rd | (|tc_hit);
    auto_d   = autoinit;
    casc_d   = cascade;
    status_d = (stat_rd ? '0 : status) | tc_hit;
    mask_d   = mask | (tc_hit & ~autoinit);
    if (smask_wr)  mask_d[wsel] = wdata[2];
    if (amask_wr)  mask_d = wdata[NCH-1:0];
    if (unmask_wr) mask_d = '0;
    if (mode_wr) begin
      auto_d[wsel] = wdata[4];
      casc_d[wsel] = (wdata[7:6] == MODE_CASCADE);
    end
    if (mclr) begin
      mask_d   = '1;
      status_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask     <= '1;
      autoinit <= '0;
      cascade  <= '0;
      status   <= '0;
    end else if (flag_en) begin
      mask     <= mask_d;
      autoinit <= auto_d;
      cascade  <= casc_d;
      status   <= status_d;
    end
  end

  assert_mclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (mask == '1 && status == '0));
  assert_stat_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !mclr && tc_hit == '0) |=> (status == '0));
  assert_tc_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_hit != '0 && !mclr) |=> ((status & $past(tc_hit)) == $past(tc_hit)));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_tc_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_hit[i] && !autoinit[i] && !smask_wr && !amask_wr && !unmask_wr) |=> mask[i]);
    assert_auto_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_hit[i] && autoinit[i] && !mask[i] && !mclr && !smask_wr && !amask_wr) |=> !mask[i]);
  end
endmodule

// File: rtl/dmac_regif.sv
module dmac_regif
  import dmac_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    xfer_tick,
  output logic [NCH-1:0]    chan_en
);
  localparam int REG_W = 2 * DATA_W;

  logic                rst_meta, rst_q;
  logic                hi_sel;
  logic                chan_port, mclr, ptr_clr;
  logic [NCH-1:0]      wr_addr, wr_cnt, tick_ok, tc_hit;
  logic [NCH-1:0]      mask, autoinit, cascade, status;
  logic [REG_W-1:0]    ch_addr [NCH];
  logic [REG_W-1:0]    ch_cnt  [NCH];
  logic [REG_W-1:0]    rd_word;
  logic [CH_W-1:0]     rd_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  always_comb begin
    chan_port = !bus_addr[3];
    mclr      = bus_wr && (bus_addr == OFS_MCLR);
    ptr_clr   = mclr || (bus_wr && bus_addr == OFS_PTRCLR);
    tick_ok   = xfer_tick & ~mask & ~cascade;
    chan_en   = ~mask;
  end

  dmac_bptr u_bptr (
    .clk    (clk),
    .rst_n  (rst_q),
    .clr    (ptr_clr),
    .step   ((bus_wr | bus_rd) & chan_port),
    .hi_sel (hi_sel)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign wr_addr[i] = bus_wr && (bus_addr == 4'(2 * i));
    assign wr_cnt[i]  = bus_wr && (bus_addr == 4'(2 * i + 1));

    dmac_chan #(.DATA_W(DATA_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_q),
      .wr_addr  (wr_addr[i]),
      .wr_cnt   (wr_cnt[i]),
      .wdata    (bus_wdata),
      .hi_sel   (hi_sel),
      .tick     (tick_ok[i]),
      .autoinit (autoinit[i]),
      .cur_addr (ch_addr[i]),
      .cur_cnt  (ch_cnt[i]),
      .tc_hit   (tc_hit[i])
    );
  end

  dmac_flags #(.DATA_W(DATA_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_q),
    .mclr      (mclr),
    .smask_wr  (bus_wr && bus_addr == OFS_SMASK),
    .amask_wr  (bus_wr && bus_addr == OFS_AMASK),
    .unmask_wr (bus_wr && bus_addr == OFS_UNMASK),
    .mode_wr   (bus_wr && bus_addr == OFS_MODE),
    .stat_rd   (bus_rd && bus_addr == OFS_STAT),
    .wdata     (bus_wdata),
    .tc_hit    (tc_hit),
    .mask      (mask),
    .autoinit  (autoinit),
    .cascade   (cascade),
    .status    (status)
  );

  always_comb begin
    rd_ch     = bus_addr[CH_W:1];
    rd_word   = bus_addr[0] ? ch_cnt[rd_ch] : ch_addr[rd_ch];
    bus_rdata = '0;
    if (bus_rd) begin
      if (chan_port)
        bus_rdata = hi_sel ? rd_word[REG_W-1:DATA_W] : rd_word[DATA_W-1:0];
      else if (bus_addr == OFS_STAT)
        bus_rdata = DATA_W'(status);
    end
  end

  assert_rst_state_R1: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(rst_q) |-> (mask == '1 && !hi_sel));
  assert_en_inv_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_wr && bus_addr == OFS_UNMASK) |=> (chan_en == '1));
endmodule

// File: tb/tb_dmac_regif.sv
module tb_dmac_regif;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [3:0] xfer_tick = '0;
  logic [3:0] chan_en;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  dmac_regif dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .xfer_tick(xfer_tick), .chan_en(chan_en)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr8(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd8(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] v);
    wr8(a, v[7:0]);
    wr8(a, v[15:8]);
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd8(a, lo);
    rd8(a, hi);
    v = {hi, lo};
  endtask

  task automatic tick(input logic [3:0] m);
    @(negedge clk);
    xfer_tick = m;
    @(negedge clk);
    xfer_tick = '0;
  endtask

  task automatic t_reset;
    logic [7:0] s;
    check("R1 chan_en after reset", chan_en, 4'h0);
    rd8(4'h8, s);
    check("R1 status after reset", s, 8'h00);
  endtask

  task automatic t_regs;
    logic [15:0] v;
    wr16(4'h4, 16'h1234);
    wr16(4'h3, 16'hABCD);
    rd16(4'h4, v); check("R2 ch2 address readback", v, 16'h1234);
    rd16(4'h3, v); check("R2 ch1 count readback", v, 16'hABCD);
    rd16(4'h0, v); check("R2 ch0 address untouched", v, 16'h0000);
  endtask

  task automatic t_ptr;
    logic [15:0] v;
    wr8(4'h0, 8'h99);
    wr8(4'hC, 8'h5A);
    wr16(4'h0, 16'h5678);
    rd16(4'h0, v); check("R3 pointer realigned by clear", v, 16'h5678);
  endtask

  task automatic t_mask;
    wr8(4'hA, 8'h01); check("R4 single unmask ch1", chan_en, 4'b0010);
    wr8(4'hF, 8'h0A); check("R4 all-mask load", chan_en, 4'b0101);
    wr8(4'hE, 8'h00); check("R4 clear all masks", chan_en, 4'b1111);
    wr8(4'hA, 8'h04); check("R4 single mask ch0", chan_en, 4'b1110);
  endtask

  task automatic t_count;
    logic [15:0] v;
    logic [7:0] s;
    wr8(4'hD, 8'h00);
    wr16(4'h6, 16'hFFFE);
    wr16(4'h7, 16'h0002);
    wr16(4'h5, 16'h0005);
    wr8(4'hB, 8'h47);
    wr8(4'hA, 8'h03);
    check("R4 ch3 unmasked", chan_en, 4'b1000);
    tick(4'b0100);
    rd16(4'h5, v); check("R5 masked ch2 count unchanged", v, 16'h0005);
    tick(4'b1000);
    tick(4'b1000);
    rd16(4'h6, v); check("R5 address wraps at 64K", v, 16'h0000);
    rd16(4'h7, v); check("R5 count after two ticks", v, 16'h0000);
    check("R6 not yet terminal", chan_en, 4'b1000);
    tick(4'b1000);
    rd16(4'h7, v); check("R6 count after final tick", v, 16'hFFFF);
    rd16(4'h6, v); check("R5 address after final tick", v, 16'h0001);
    check("R6 channel masked at terminal count", chan_en, 4'b0000);
    rd8(4'h8, s); check("R8 status shows ch3", s, 8'h08);
    rd8(4'h8, s); check("R8 status cleared by read", s, 8'h00);
  endtask

  task automatic t_auto;
    logic [15:0] v;
    logic [7:0] s;
    wr8(4'hD, 8'h00);
    wr16(4'h0, 16'h0100);
    wr16(4'h1, 16'h0001);
    wr8(4'hB, 8'h54);
    wr8(4'hA, 8'h00);
    tick(4'b0001);
    rd16(4'h0, v); check("R5 ch0 address advanced", v, 16'h0101);
    tick(4'b0001);
    rd16(4'h0, v); check("R7 address reloaded", v, 16'h0100);
    rd16(4'h1, v); check("R7 count reloaded", v, 16'h0001);
    check("R7 channel stays enabled", chan_en, 4'b0001);
    rd8(4'h8, s); check("R7 status bit set", s, 8'h01);
  endtask

  task automatic t_stat_race;
    logic [7:0] s;
    wr8(4'hD, 8'h00);
    wr16(4'h3, 16'h0000);
    wr8(4'hB, 8'h45);
    wr8(4'hA, 8'h01);
    @(negedge clk);
    bus_addr = 4'h8; bus_rd = 1'b1; xfer_tick = 4'b0010;
    #1 s = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; xfer_tick = '0;
    check("R8 read before terminal count", s, 8'h00);
    rd8(4'h8, s); check("R8 same-cycle terminal count kept", s, 8'h02);
  endtask

  task automatic t_mclr;
    logic [15:0] v;
    logic [7:0] s;
    wr8(4'hD, 8'h00);
    wr16(4'h1, 16'h0000);
    wr8(4'hB, 8'h44);
    wr8(4'hE, 8'h00);
    tick(4'b0001);
    wr8(4'h2, 8'h77);
    wr8(4'hE, 8'h00);
    wr8(4'hD, 8'hFF);
    check("R9 all masked", chan_en, 4'b0000);
    rd8(4'h8, s); check("R9 status cleared", s, 8'h00);
    wr16(4'h2, 16'h1234);
    rd16(4'h2, v); check("R9 pointer back to low", v, 16'h1234);
  endtask

  task automatic t_cascade;
    logic [15:0] v;
    wr8(4'hD, 8'h00);
    wr16(4'h5, 16'h0003);
    wr8(4'hB, 8'hC2);
    wr8(4'hA, 8'h02);
    tick(4'b0100);
    rd16(4'h5, v); check("R10 cascade ignores tick", v, 16'h0003);
    check("R10 cascade channel enabled", chan_en, 4'b0100);
    wr8(4'hB, 8'h46);
    tick(4'b0100);
    rd16(4'h5, v); check("R10 single mode counts again", v, 16'h0002);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_regs;
    t_ptr;
    t_mask;
    t_count;
    t_auto;
    t_stat_race;
    t_mclr;
    t_cascade;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule